// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps the local time of a node that takes part in a precision time protocol. The time is two 32-bit registers: whole seconds and a subsecond count. The counter advances every clock in one of two ways. In the direct mode it adds a small programmable step to the subsecond field. In the trimmed mode a 32-bit addend drives a phase accumulator, and the step is applied only on the clocks where that accumulator overflows. This lets software tune the rate of the clock in very fine increments. The subsecond field can wrap at a decimal nanosecond limit or at a binary limit.

Software controls the counter through one command strobe with an opcode and two data words. The commands are: load an absolute time, shift the time forward or backward by a signed offset, and retune the rate addend. Each command has its own busy bit, which lasts for one clock. The outputs are the running seconds and subsecond values and a one-clock pulse that marks each second boundary reached by counting. A pulse-per-second generator downstream can use that pulse.

Top module: `ptp_tod_counter`

## Requirements
- R1: While rst_n is low at a clock edge, the seconds and subsecond outputs are cleared, tod_pulse and all busy bits are 0, and the rate addend returns to its nominal value 0x80000000.
- R2: With cfg_fine = 0 and no time command accepted, tod_sub grows by cfg_incr on every clock.
- R3: With cfg_decimal = 1 the subsecond limit is 999,999,999. A count step that passes the limit leaves tod_sub equal to the sum minus 1,000,000,000 and adds one to tod_sec.
- R4: With cfg_decimal = 0 the subsecond limit is 0x7FFFFFFF. A step that passes the limit subtracts 0x80000000 from the sum and adds one to tod_sec.
- R5: With cfg_fine = 1 the addend is added into a 32-bit accumulator every clock. The cfg_incr step is applied only on clocks where that sum overflows. At the nominal addend this is exactly one step every two clocks.
- R6: Opcode 2 (rate) sets the addend to 0x80000000 plus cmd_sub read as a signed 32-bit value, modulo 2^32. The new addend is used from the next clock.
- R7: tod_pulse is high for exactly the one clock after counting carries into tod_sec. This includes the carry where tod_sec wraps from 0xFFFFFFFF to 0. Commands never raise the pulse.
- R8: Opcode 0 (set) copies cmd_sec and cmd_sub into the time. No count step happens on that clock.
- R9: Opcode 1 (shift) with cmd_neg = 0 adds cmd_sec and cmd_sub to the time. A subsecond sum above the active limit carries one into the seconds. No count step happens on that clock.
- R10: Opcode 1 with cmd_neg = 1 subtracts the offset. When the subsecond field would go negative, it borrows (limit + 1) from the seconds field.
- R11: busy[n] goes high for the one clock after a command with opcode n is accepted. A command with the same opcode that arrives while busy[n] is high is ignored. A command with a different opcode is still accepted.
- R12: Opcode 3 is reserved. It changes neither the time nor any busy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fine | input | 1 | 1 selects accumulator-trimmed counting, 0 the direct step |
| cfg_decimal | input | 1 | 1 selects the decimal subsecond limit, 0 the binary one |
| cfg_incr | input | 8 | Subsecond step added on each counting clock |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode: 0 set, 1 shift, 2 rate, 3 reserved |
| cmd_sec | input | 32 | Seconds value or seconds offset |
| cmd_sub | input | 32 | Subsecond value, subsecond offset, or signed rate adjustment |
| cmd_neg | input | 1 | Shift direction, 1 subtracts |
| busy | output | 3 | Per-opcode busy bits, bit n for opcode n |
| tod_sec | output | 32 | Running seconds |
| tod_sub | output | 32 | Running subsecond count |
| tod_pulse | output | 1 | One-clock second-boundary pulse |

## Verification
The bench aims at the wrap points of both limits, a seconds wrap from all ones, and a shift whose subsecond part carries or borrows. A design that mixes up the limits, or that wraps by the limit instead of the limit plus one, is off by one count. A design that drops the borrow leaves a seconds value one second too high. It also issues the same opcode back to back, follows with a different opcode, and sends the reserved opcode. A busy bit that sticks or a shared busy bit would then lose a command, and a decode leak would corrupt the time. In trimmed mode the rate is measured over fixed windows at three addends whose step counts are exact. An addend applied on the wrong clock, or one built without its sign, changes those counts.

// File: rtl/ptp_tod_pkg.sv
// Package: shared opcode encoding and constants for the time-of-day counter.
// Assumes opcodes are 2 bits wide and that only the first three are defined.
package ptp_tod_pkg;

    typedef enum logic [1:0] {
        TOD_OP_SET   = 2'd0,
        TOD_OP_SHIFT = 2'd1,
        TOD_OP_RATE  = 2'd2,
        TOD_OP_RSVD  = 2'd3
    } tod_op_e;

    localparam int TOD_OP_W   = 2;
    localparam int TOD_N_CMDS = 3;

endpackage

// File: rtl/ptp_tod_cmd.sv
// Module: command gate. It decodes the opcode into one accept strobe per
// command and keeps one busy bit per command. Each busy bit is high for the
// single clock after its command is accepted and blocks that command only.
// Assumes the caller presents at most one opcode per clock.
module ptp_tod_cmd #(
    parameter int N_CMDS = 3,
    parameter int OP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    output logic [N_CMDS-1:0] accept,
    output logic [N_CMDS-1:0] busy
);

    logic [N_CMDS-1:0] busy_q;

    generate
        for (genvar g = 0; g < N_CMDS; g++) begin : g_cmd
            // Accept a command when its opcode matches and its busy bit is clear.
            assign accept[g] = cmd_valid && (cmd_op == OP_W'(g)) && !busy_q[g];

            // Hold the busy bit for exactly one clock after an accept.
            always_ff @(posedge clk) begin
                if (!rst_n) busy_q[g] <= 1'b0;
                else        busy_q[g] <= accept[g];
            end

            // R11: a busy bit never lasts two clocks in a row.
            p_busy_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
                busy_q[g] |=> !busy_q[g]);
        end
    endgenerate

    assign busy = busy_q;

endmodule

// File: rtl/ptp_tod_rate.sv
// Module: rate trimmer. It holds the addend and the phase accumulator and
// emits a step enable on every clock where the accumulator sum overflows.
// Assumes the load adjustment is a two's complement value of width W.
module ptp_tod_rate #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] adj,
    output logic         step
);

    localparam logic [W-1:0] NOMINAL = W'(1) << (W - 1);

    logic [W-1:0] acc_q;
    logic [W-1:0] addend_q;
    logic [W:0]   sum;

    // Combine the accumulator with the current addend; the top bit is the overflow.
    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, addend_q};
        step = sum[W];
    end

    // Advance the accumulator every clock, including clocks that carry a command.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[W-1:0];
    end

    // Reload the addend around its nominal value when a rate command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)    addend_q <= NOMINAL;
        else if (load) addend_q <= NOMINAL + adj;
    end

    // R6: after a load the addend is the nominal value shifted by the adjustment.
    p_rate_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addend_q == NOMINAL + $past(adj));

    // R6: without a load the addend keeps its value.
    p_rate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addend_q));

endmodule

// File: rtl/ptp_tod_offset.sv
// Module: offset arithmetic. It adds or subtracts a seconds/subsecond offset
// to a time value. The carry or borrow between the fields uses the active
// subsecond limit. Assumes both subsecond inputs are at or below the limit.
module ptp_tod_offset #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 32
) (
    input  logic [SEC_W-1:0] cur_sec,
    input  logic [SUB_W-1:0] cur_sub,
    input  logic [SEC_W-1:0] off_sec,
    input  logic [SUB_W-1:0] off_sub,
    input  logic             neg,
    input  logic [SUB_W-1:0] limit,
    output logic [SEC_W-1:0] new_sec,
    output logic [SUB_W-1:0] new_sub
);

    logic [SUB_W:0] span;
    logic [SUB_W:0] add_sum;
    logic           add_carry;
    logic           sub_borrow;

    // Work out both directions and pick the one requested.
    always_comb begin
        span       = {1'b0, limit} + (SUB_W+1)'(1);
        add_sum    = {1'b0, cur_sub} + {1'b0, off_sub};
        add_carry  = add_sum > {1'b0, limit};
        sub_borrow = cur_sub < off_sub;
        if (!neg) begin
            new_sub = add_carry ? SUB_W'(add_sum - span) : add_sum[SUB_W-1:0];
            new_sec = cur_sec + off_sec + SEC_W'(add_carry);
        end else begin
            new_sub = sub_borrow ? SUB_W'({1'b0, cur_sub} + span - {1'b0, off_sub})
                                 : cur_sub - off_sub;
            new_sec = cur_sec - off_sec - SEC_W'(sub_borrow);
        end
    end

endmodule

// File: rtl/ptp_tod_counter.sv
// Module: time-of-day counter top. It holds the seconds and subsecond
// registers, counts in direct or trimmed mode, wraps at a decimal or binary
// limit, and applies the set, shift and rate commands. It pulses for one
// clock at each second boundary reached by counting.
// Assumes the configuration inputs are quasi-static and that loaded
// subsecond values respect the active limit.
module ptp_tod_counter #(
    parameter int SEC_W     = 32,
    parameter int SUB_W     = 32,
    parameter int INC_W     = 8,
    parameter int DEC_LIMIT = 999_999_999
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_fine,
    input  logic                               cfg_decimal,
    input  logic [INC_W-1:0]                   cfg_incr,
    input  logic                               cmd_valid,
    input  logic [ptp_tod_pkg::TOD_OP_W-1:0]   cmd_op,
    input  logic [SEC_W-1:0]                   cmd_sec,
    input  logic [SUB_W-1:0]                   cmd_sub,
    input  logic                               cmd_neg,
    output logic [ptp_tod_pkg::TOD_N_CMDS-1:0] busy,
    output logic [SEC_W-1:0]                   tod_sec,
    output logic [SUB_W-1:0]                   tod_sub,
    output logic                               tod_pulse
);
    import ptp_tod_pkg::*;

    localparam logic [SUB_W-1:0] BIN_LIM = SUB_W'((64'd1 << (SUB_W - 1)) - 64'd1);
    localparam logic [SUB_W-1:0] DEC_LIM = SUB_W'(DEC_LIMIT);

    logic [TOD_N_CMDS-1:0] accept;
    logic                  acc_step;
    logic [SUB_W-1:0]      limit;
    logic                  count_en;
    logic [SUB_W:0]        tick_sum;
    logic                  tick_wrap;
    logic                  time_cmd;
    logic [SEC_W-1:0]      shift_sec;
    logic [SUB_W-1:0]      shift_sub;
    logic [SEC_W-1:0]      sec_q;
    logic [SUB_W-1:0]      sub_q;
    logic                  pulse_q;

    ptp_tod_cmd #(
        .N_CMDS(TOD_N_CMDS),
        .OP_W  (TOD_OP_W)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .accept   (accept),
        .busy     (busy)
    );

    ptp_tod_rate #(
        .W(SUB_W)
    ) u_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept[TOD_OP_RATE]),
        .adj  (cmd_sub),
        .step (acc_step)
    );

    ptp_tod_offset #(
        .SEC_W(SEC_W),
        .SUB_W(SUB_W)
    ) u_offset (
        .cur_sec(sec_q),
        .cur_sub(sub_q),
        .off_sec(cmd_sec),
        .off_sub(cmd_sub),
        .neg    (cmd_neg),
        .limit  (limit),
        .new_sec(shift_sec),
        .new_sub(shift_sub)
    );

    // Pick the wrap limit and form the counting step for this clock.
    always_comb begin
        limit     = cfg_decimal ? DEC_LIM : BIN_LIM;
        count_en  = !cfg_fine || acc_step;
        tick_sum  = {1'b0, sub_q} + (count_en ? (SUB_W+1)'(cfg_incr) : '0);
        tick_wrap = tick_sum > {1'b0, limit};
        time_cmd  = accept[TOD_OP_SET] || accept[TOD_OP_SHIFT];
    end

    // Update the time: a set or shift replaces the count step for this clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            sub_q <= '0;
        end else if (accept[TOD_OP_SET]) begin
            sec_q <= cmd_sec;
            sub_q <= cmd_sub;
        end else if (accept[TOD_OP_SHIFT]) begin
            sec_q <= shift_sec;
            sub_q <= shift_sub;
        end else if (tick_wrap) begin
            sec_q <= sec_q + SEC_W'(1);
            sub_q <= SUB_W'(tick_sum - ({1'b0, limit} + (SUB_W+1)'(1)));
        end else begin
            sub_q <= tick_sum[SUB_W-1:0];
        end
    end

    // Raise the boundary pulse only when counting carried into the seconds.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= tick_wrap && !time_cmd;
    end

    assign tod_sec   = sec_q;
    assign tod_sub   = sub_q;
    assign tod_pulse = pulse_q;

    // R7: the pulse always comes with a one-second advance.
    p_pulse_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tod_pulse |-> tod_sec == $past(tod_sec) + SEC_W'(1));

    // R8: a set command lands both fields exactly.
    p_set_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept[TOD_OP_SET] |=> (tod_sec == $past(cmd_sec)) && (tod_sub == $past(cmd_sub)));

    // R2: direct counting below the limit adds the step and leaves the seconds alone.
    p_direct_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fine && !time_cmd && (({1'b0, tod_sub} + (SUB_W+1)'(cfg_incr)) <= {1'b0, limit}))
        |=> (tod_sub == $past(tod_sub) + SUB_W'($past(cfg_incr))) && $stable(tod_sec));

    // R5: in trimmed mode a clock without accumulator overflow holds the time.
    p_trim_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fine && !acc_step && !time_cmd) |=> $stable(tod_sub) && $stable(tod_sec));

    // R12: the reserved opcode is never accepted.
    p_reserved_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == TOD_OP_RSVD) |-> accept == '0);

endmodule

// File: tb/sim_ptp_tod_counter.sv
// Bench: a behavioural reference model of the time counter, compared with
// the design on every falling edge, plus directed checks with hand-worked values.
module sim_ptp_tod_counter;

    localparam longint M32 = 64'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fine = 1'b0;
    logic        cfg_decimal = 1'b1;
    logic [7:0]  cfg_incr = 8'd8;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_sec = '0;
    logic [31:0] cmd_sub = '0;
    logic        cmd_neg = 1'b0;
    logic [2:0]  busy;
    logic [31:0] tod_sec;
    logic [31:0] tod_sub;
    logic        tod_pulse;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    longint m_sec, m_sub, m_acc, m_add, m_lim, s, sum;
    bit     m_pulse, carry, acc_ok, brw;
    bit     m_busy [3];
    int     op;

    always #4 clk = ~clk;

    ptp_tod_counter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fine(cfg_fine), .cfg_decimal(cfg_decimal),
        .cfg_incr(cfg_incr), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sec(cmd_sec),
        .cmd_sub(cmd_sub), .cmd_neg(cmd_neg), .busy(busy), .tod_sec(tod_sec),
        .tod_sub(tod_sub), .tod_pulse(tod_pulse)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: advances on each rising edge from the inputs held stable.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_sub = 0; m_acc = 0; m_add = 64'h8000_0000; m_pulse = 0;
            for (int i = 0; i < 3; i++) m_busy[i] = 0;
        end else begin
            op     = int'(cmd_op);
            acc_ok = cmd_valid && op < 3 && !m_busy[op];
            sum    = m_acc + m_add;
            carry  = sum > M32;
            m_acc  = sum & M32;
            m_lim  = cfg_decimal ? 64'd999_999_999 : 64'h7FFF_FFFF;
            m_pulse = 0;
            if (acc_ok && op == 0) begin
                m_sec = cmd_sec; m_sub = cmd_sub;
            end else if (acc_ok && op == 1) begin
                if (!cmd_neg) begin
                    s = m_sub + cmd_sub;
                    brw = s > m_lim;
                    if (brw) s = s - m_lim - 1;
                    m_sec = (m_sec + cmd_sec + brw) & M32;
                end else begin
                    brw = m_sub < cmd_sub;
                    s = brw ? m_sub + m_lim + 1 - cmd_sub : m_sub - cmd_sub;
                    m_sec = (m_sec - cmd_sec - brw) & M32;
                end
                m_sub = s;
            end else begin
                if (!cfg_fine || carry) m_sub = m_sub + cfg_incr;
                if (m_sub > m_lim) begin
                    m_sub = m_sub - m_lim - 1;
                    m_sec = (m_sec + 1) & M32;
                    m_pulse = 1;
                end
            end
            if (acc_ok && op == 2) m_add = (64'h8000_0000 + longint'($signed(cmd_sub))) & M32;
            for (int i = 0; i < 3; i++) m_busy[i] = acc_ok && (op == i);
        end
        started = 1;
        cycles++;
    end

    // Compare design and model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, "sec", tod_sec, m_sec);
            chk(cur_req, "sub", tod_sub, m_sub);
            chk("R7", "pulse", tod_pulse, m_pulse);
            chk("R11", "busy", busy, {m_busy[2], m_busy[1], m_busy[0]});
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic send(input logic [1:0] o, input logic [31:0] sc, input logic [31:0] sb,
                        input logic ng);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = o; cmd_sec = sc; cmd_sub = sb; cmd_neg = ng;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    logic [31:0] mark;

    initial begin
        // R1: reset state.
        idle(3);
        chk("R1", "sec", tod_sec, 0);
        chk("R1", "sub", tod_sub, 0);
        chk("R1", "pulse", tod_pulse, 0);
        chk("R1", "busy", busy, 0);
        rst_n = 1'b1;

        // R2: direct counting with step 8.
        cur_req = "R2";
        idle(20);

        // R8 then R3 and R7: set just below the decimal limit.
        cur_req = "R8";
        send(2'd0, 32'd5, 32'd999_999_990, 1'b0);
        chk("R8", "sec", tod_sec, 5);
        chk("R8", "sub", tod_sub, 999_999_990);
        chk("R11", "busy after set", busy, 3'b001);
        cur_req = "R3";
        @(negedge clk);
        chk("R3", "sub", tod_sub, 999_999_998);
        @(negedge clk);
        chk("R3", "sec", tod_sec, 6);
        chk("R3", "sub", tod_sub, 6);
        chk("R7", "pulse", tod_pulse, 1);
        @(negedge clk);
        chk("R7", "pulse gone", tod_pulse, 0);

        // R9: shift forward with subsecond carry.
        cur_req = "R9";
        send(2'd0, 32'd10, 32'd999_999_000, 1'b0);
        send(2'd1, 32'd2, 32'd1000, 1'b0);
        chk("R9", "sec", tod_sec, 13);
        chk("R9", "sub", tod_sub, 8);
        chk("R7", "no pulse on shift", tod_pulse, 0);

        // R10: shift backward with borrow.
        cur_req = "R10";
        send(2'd1, 32'd4, 32'd20, 1'b1);
        chk("R10", "sec", tod_sec, 8);
        chk("R10", "sub", tod_sub, 999_999_996);

        // R11: same opcode back to back is dropped, another opcode is taken.
        cur_req = "R11";
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_sec = 32'd1; cmd_sub = 32'd0; cmd_neg = 1'b0;
        @(negedge clk);
        chk("R11", "busy shift", busy, 3'b010);
        mark = tod_sec;
        @(negedge clk);
        chk("R11", "second shift ignored", tod_sec, longint'(mark));
        cmd_op = 2'd0; cmd_sec = 32'd100; cmd_sub = 32'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R11", "other opcode taken sec", tod_sec, 100);
        chk("R11", "other opcode taken sub", tod_sub, 0);

        // R12: reserved opcode has no effect.
        cur_req = "R12";
        send(2'd3, 32'd777, 32'd777, 1'b0);
        chk("R12", "busy", busy, 0);
        chk("R12", "sec", tod_sec, 100);
        chk("R12", "sub", tod_sub, 16);

        // R7: seconds wrap from all ones.
        cur_req = "R7";
        send(2'd0, 32'hFFFF_FFFF, 32'd999_999_999, 1'b0);
        @(negedge clk);
        chk("R7", "sec wrap", tod_sec, 0);
        chk("R7", "sub wrap", tod_sub, 7);
        chk("R7", "pulse at wrap", tod_pulse, 1);

        // R4: binary limit with step 5.
        cur_req = "R4";
        @(negedge clk);
        cfg_decimal = 1'b0; cfg_incr = 8'd5;
        send(2'd0, 32'd1, 32'h7FFF_FFFC, 1'b0);
        @(negedge clk);
        chk("R4", "sec", tod_sec, 2);
        chk("R4", "sub", tod_sub, 1);
        idle(10);

        // R5: trimmed mode at the nominal addend, step 10.
        cur_req = "R5";
        @(negedge clk);
        cfg_decimal = 1'b1; cfg_incr = 8'd10; cfg_fine = 1'b1;
        send(2'd0, 32'd0, 32'd0, 1'b0);
        mark = tod_sub;
        idle(20);
        chk("R5", "advance over 20 clocks", tod_sub - mark, 100);

        // R6: rate up by a quarter, then down by a quarter.
        cur_req = "R6";
        send(2'd2, 32'd0, 32'h4000_0000, 1'b0);
        mark = tod_sub;
        idle(40);
        chk("R6", "advance fast", tod_sub - mark, 300);
        send(2'd2, 32'd0, 32'hC000_0000, 1'b0);
        mark = tod_sub;
        idle(40);
        chk("R6", "advance slow", tod_sub - mark, 100);

        // R1: reset again restores the nominal rate.
        cur_req = "R1";
        rst_n = 1'b0;
        idle(2);
        chk("R1", "sec", tod_sec, 0);
        chk("R1", "busy", busy, 0);
        rst_n = 1'b1;
        mark = tod_sub;
        idle(20);
        chk("R1", "nominal rate", tod_sub - mark, 100);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule